// File: doc/BRIEF.md
# Indexed Byte-Register AHB Master Bridge

This block gives a host, which can only reach a bank of byte-wide indexed configuration registers, a way to perform single transfers on an AHB-Lite bus as a master. The host loads a 32-bit target address and a 32-bit data word into staging registers, one byte per index and most significant byte first. It also selects the access width with a type byte. It then starts the access. A write access starts when a key byte is written to the trigger index. A read access starts when the trigger index is simply read. The read result lands back in the data staging registers, where the host fetches it byte by byte.

Each start produces exactly one AHB-Lite NONSEQ transfer of burst type SINGLE. The bridge keeps the address phase until HREADY accepts it and then waits out the data phase. An error response is kept in a sticky status bit. Reading the trigger index returns a status byte, so the host can watch the busy flag and the error flag.

Top module: `idx_ahb_master`

## Requirements
- R1: After a synchronous reset, HTRANS is IDLE (2'b00), all staging registers and the enable register read 0, and the read-data output is 0.
- R2: Index 0x30 is the enable register, readable and writable at all times. The bridge is active only while it holds 0x01. While it is inactive, writes to indices 0xF0–0xFE are ignored, reads of those indices return 0, and no transfer starts. Staged values survive a disable and re-enable.
- R3: Indices 0xF0, 0xF1, 0xF2 and 0xF3 hold address bits 31:24, 23:16, 15:8 and 7:0. Indices 0xF4 to 0xF7 hold data bits 31:24 down to 7:0 in the same order. Index 0xF8 holds the type byte. Each of them reads back the last value stored.
- R4: Writing 0xCF to index 0xFE starts one write transfer (HWRITE=1) to the staged address. A write of any other value to index 0xFE starts nothing.
- R5: A read of index 0xFE while idle starts one read transfer (HWRITE=0). After it completes, the word is available at indices 0xF4–0xF7.
- R6: Type 0 gives HSIZE 0 (byte), type 1 gives HSIZE 1 (halfword), and any other type gives HSIZE 2 (word). HADDR carries the staged address with bit 0 cleared for halfwords and bits 1:0 cleared for words.
- R7: Write data on HWDATA is the staged data for a word. For a halfword it is data bits 15:0 repeated in both halves. For a byte it is data bits 7:0 repeated in all four lanes.
- R8: Read data from a byte or halfword access is taken from the lane chosen by the address low bits and is placed in bits 7:0 or 15:0 of the data staging word, with the upper bits zero.
- R9: Each start yields exactly one NONSEQ address phase. That phase is held with a stable address and controls while HREADY is low, and HTRANS returns to IDLE once HREADY accepts it. The bridge stays busy until HREADY completes the data phase.
- R10: A read of index 0xFE returns bit 0 = busy and bit 1 = error, with the other bits zero. Start requests of either kind that arrive while busy are ignored.
- R11: The error bit is set by HRESP=ERROR during a data phase and stays set across later successful transfers. It clears only on reset or on a write of a value other than 0xCF to index 0xFE. A failed read leaves the data staging registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe, one cycle per byte |
| cfg_rd | input | 1 | Register read strobe, one cycle per byte |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Write byte |
| cfg_rdata | output | 8 | Read byte, valid the cycle after cfg_rd |
| haddr | output | 32 | AHB address |
| htrans | output | 2 | AHB transfer type (IDLE or NONSEQ) |
| hwrite | output | 1 | AHB direction, 1 = write |
| hsize | output | 3 | AHB transfer size |
| hburst | output | 3 | AHB burst type, always SINGLE |
| hwdata | output | 32 | AHB write data |
| hrdata | input | 32 | AHB read data |
| hready | input | 1 | AHB transfer done / address accepted |
| hresp | input | 1 | AHB response, 1 = ERROR |

## Verification
The assertions on address-phase holding and on the single-beat shape take for granted that the subordinate follows AHB-Lite. HREADY is low only inside a data phase, and an ERROR response takes two cycles, the first with HREADY low. The bench's subordinate model keeps to this: it raises HREADY whenever no data phase is open, inserts a configurable count of wait cycles, and stretches any error response to at least one wait cycle. Host strobes never assert write and read in the same cycle. The host also never touches the data staging indices while a transfer is open, so completions never race host writes.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int IDX_W      = 8;
  localparam int BYTE_W     = 8;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / BYTE_W;

  // index map: host software depends on these positions
  localparam int IX_ENABLE = 'h30;
  localparam int IX_ADDR0  = 'hF0;
  localparam int IX_DATA0  = 'hF4;
  localparam int IX_KIND   = 'hF8;
  localparam int IX_GO     = 'hFE;

  localparam logic [BYTE_W-1:0] ENABLE_KEY = 8'h01;
  localparam logic [BYTE_W-1:0] GO_KEY     = 8'hCF;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} xfer_st_t;

  function automatic logic idx_is(input logic [IDX_W-1:0] idx, input int base);
    return idx == IDX_W'(base);
  endfunction

  function automatic logic [2:0] kind_to_size(input logic [BYTE_W-1:0] kind);
    case (kind)
      8'd0:    return 3'd0;
      8'd1:    return 3'd1;
      default: return 3'($clog2(WORD_BYTES));
    endcase
  endfunction
endpackage

// File: rtl/idx_stage_regs.sv
module idx_stage_regs
  import bridge_pkg::*;
#(
  parameter int NB = WORD_BYTES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                cap_en,
  input  logic [NB*BYTE_W-1:0] cap_word,
  input  logic [BYTE_W-1:0]   status_byte,
  output logic                enabled,
  output logic [NB*BYTE_W-1:0] addr_word,
  output logic [NB*BYTE_W-1:0] data_word,
  output logic [BYTE_W-1:0]   kind_byte,
  output logic [BYTE_W-1:0]   rd_byte
);
  localparam int W = NB * BYTE_W;

  logic [BYTE_W-1:0] en_q;
  logic [BYTE_W-1:0] kind_q;
  logic [W-1:0]      addr_q;
  logic [W-1:0]      data_q;

  assign enabled   = (en_q == ENABLE_KEY);
  assign addr_word = addr_q;
  assign data_word = data_q;
  assign kind_byte = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      kind_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_en && idx_is(idx, IX_ENABLE)) en_q <= wdata;
      if (wr_en && enabled && idx_is(idx, IX_KIND)) kind_q <= wdata;
      for (int b = 0; b < NB; b++) begin
        // byte b of the index window is the b-th most significant byte
        if (wr_en && enabled && idx_is(idx, IX_ADDR0 + b))
          addr_q[(NB-1-b)*BYTE_W +: BYTE_W] <= wdata;
        if (cap_en)
          data_q[(NB-1-b)*BYTE_W +: BYTE_W] <= cap_word[(NB-1-b)*BYTE_W +: BYTE_W];
        else if (wr_en && enabled && idx_is(idx, IX_DATA0 + b))
          data_q[(NB-1-b)*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    if (idx_is(idx, IX_ENABLE)) begin
      rd_byte = en_q;
    end else if (enabled) begin
      if (idx_is(idx, IX_KIND)) rd_byte = kind_q;
      if (idx_is(idx, IX_GO))   rd_byte = status_byte;
      for (int b = 0; b < NB; b++) begin
        if (idx_is(idx, IX_ADDR0 + b)) rd_byte = addr_q[(NB-1-b)*BYTE_W +: BYTE_W];
        if (idx_is(idx, IX_DATA0 + b)) rd_byte = data_q[(NB-1-b)*BYTE_W +: BYTE_W];
      end
    end
  end
endmodule

// File: rtl/ahb_single_master.sv
module ahb_single_master
  import bridge_pkg::*;
#(
  parameter int AW = WORD_W,
  parameter int DW = WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_wr,
  input  logic [AW-1:0]     start_addr,
  input  logic [BYTE_W-1:0] start_kind,
  input  logic [DW-1:0]     start_data,
  input  logic              err_clr,
  output logic [AW-1:0]     haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DW-1:0]     hwdata,
  input  logic [DW-1:0]     hrdata,
  input  logic              hready,
  input  logic              hresp,
  output logic              busy,
  output logic              err,
  output logic              cap_en,
  output logic [DW-1:0]     cap_word
);
  localparam int LANES     = DW / BYTE_W;
  localparam int LANE_BITS = $clog2(LANES);

  xfer_st_t          st;
  logic              err_q;
  logic [2:0]        sz;
  logic [AW-1:0]     al_addr;
  logic [DW-1:0]     lane_data;
  logic [DW-1:0]     ext;
  logic [LANE_BITS-1:0] lane;

  assign hburst = 3'b000;
  assign err    = err_q;
  assign busy   = (st != ST_IDLE) || cap_en;
  assign sz     = kind_to_size(start_kind);
  assign lane   = haddr[LANE_BITS-1:0];

  // address alignment and lane replication at launch
  always_comb begin
    case (sz)
      3'd0: begin
        al_addr   = start_addr;
        lane_data = {LANES{start_data[BYTE_W-1:0]}};
      end
      3'd1: begin
        al_addr   = {start_addr[AW-1:1], 1'b0};
        lane_data = {(LANES/2){start_data[2*BYTE_W-1:0]}};
      end
      default: begin
        al_addr   = {start_addr[AW-1:LANE_BITS], LANE_BITS'(0)};
        lane_data = start_data;
      end
    endcase
  end

  // lane extraction of returned data, right-justified
  always_comb begin
    case (hsize)
      3'd0:    ext = DW'(hrdata[{lane, 3'b000} +: BYTE_W]);
      3'd1:    ext = DW'(hrdata[{lane[LANE_BITS-1:1], 4'b0000} +: 2*BYTE_W]);
      default: ext = hrdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      htrans   <= HT_IDLE;
      haddr    <= '0;
      hwrite   <= 1'b0;
      hsize    <= '0;
      hwdata   <= '0;
      err_q    <= 1'b0;
      cap_en   <= 1'b0;
      cap_word <= '0;
    end else begin
      cap_en <= 1'b0;
      if (err_clr) err_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_ADDR;
          htrans <= HT_NONSEQ;
          haddr  <= al_addr;
          hwrite <= start_wr;
          hsize  <= sz;
          hwdata <= lane_data;
        end
        ST_ADDR: if (hready) begin
          st     <= ST_DATA;
          htrans <= HT_IDLE;
        end
        ST_DATA: begin
          if (hresp) err_q <= 1'b1;
          if (hready) begin
            st <= ST_IDLE;
            if (!hwrite && !hresp) begin
              cap_en   <= 1'b1;
              cap_word <= ext;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_ahb_master.sv
module idx_ahb_master
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  output logic [WORD_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [WORD_W-1:0] hwdata,
  input  logic [WORD_W-1:0] hrdata,
  input  logic              hready,
  input  logic              hresp
);
  logic              enabled;
  logic [WORD_W-1:0] addr_word;
  logic [WORD_W-1:0] data_word;
  logic [BYTE_W-1:0] kind_byte;
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] status_byte;
  logic              busy;
  logic              err;
  logic              cap_en;
  logic [WORD_W-1:0] cap_word;
  logic              go_hit;
  logic              go_wr;
  logic              go_rd;
  logic              start;
  logic              err_clr;

  assign go_hit      = enabled && idx_is(cfg_idx, IX_GO);
  assign go_wr       = go_hit && cfg_wr && (cfg_wdata == GO_KEY);
  assign go_rd       = go_hit && cfg_rd && !cfg_wr;
  assign start       = (go_wr || go_rd) && !busy;
  assign err_clr     = go_hit && cfg_wr && (cfg_wdata != GO_KEY);
  assign status_byte = {{(BYTE_W-2){1'b0}}, err, busy};

  idx_stage_regs #(.NB(WORD_BYTES)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (cfg_wr),
    .idx         (cfg_idx),
    .wdata       (cfg_wdata),
    .cap_en      (cap_en),
    .cap_word    (cap_word),
    .status_byte (status_byte),
    .enabled     (enabled),
    .addr_word   (addr_word),
    .data_word   (data_word),
    .kind_byte   (kind_byte),
    .rd_byte     (rd_byte)
  );

  ahb_single_master #(.AW(WORD_W), .DW(WORD_W)) u_mst (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_wr   (go_wr),
    .start_addr (addr_word),
    .start_kind (kind_byte),
    .start_data (data_word),
    .err_clr    (err_clr),
    .haddr      (haddr),
    .htrans     (htrans),
    .hwrite     (hwrite),
    .hsize      (hsize),
    .hburst     (hburst),
    .hwdata     (hwdata),
    .hrdata     (hrdata),
    .hready     (hready),
    .hresp      (hresp),
    .busy       (busy),
    .err        (err),
    .cap_en     (cap_en),
    .cap_word   (cap_word)
  );

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_byte;
  end
endmodule

// File: rtl/idx_ahb_master_chk.sv
module idx_ahb_master_chk
  import bridge_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [1:0]        htrans,
  input logic [WORD_W-1:0] haddr,
  input logic [2:0]        hsize,
  input logic              hwrite,
  input logic              hready
);
  // R9: only IDLE or NONSEQ ever appear
  p_trans_kind_r9: assert property (@(posedge clk) disable iff (rst)
    (htrans == HT_IDLE) || (htrans == HT_NONSEQ));

  // R9: a stalled address phase keeps its address and controls
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (htrans == HT_NONSEQ && !hready) |=>
      (htrans == HT_NONSEQ) && $stable(haddr) && $stable(hwrite) && $stable(hsize));

  // R9: an accepted address phase is followed by IDLE
  p_single_beat_r9: assert property (@(posedge clk) disable iff (rst)
    (htrans == HT_NONSEQ && hready) |=> (htrans == HT_IDLE));

  // R6: size never exceeds a word and the address is aligned to it
  p_size_align_r6: assert property (@(posedge clk) disable iff (rst)
    (htrans == HT_NONSEQ) |->
      (hsize <= 3'd2) &&
      ((hsize != 3'd1) || (haddr[0] == 1'b0)) &&
      ((hsize != 3'd2) || (haddr[1:0] == 2'b00)));
endmodule

bind idx_ahb_master idx_ahb_master_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .htrans (htrans),
  .haddr  (haddr),
  .hsize  (hsize),
  .hwrite (hwrite),
  .hready (hready)
);

// File: tb/idx_ahb_master_bench.sv
module idx_ahb_master_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0]  cfg_idx = '0, cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [31:0] haddr, hwdata;
  logic [31:0] hrdata = '0;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize, hburst;
  logic        hready = 1'b1, hresp = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_ahb_master u_idx_ahb_master (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
    .hrdata(hrdata), .hready(hready), .hresp(hresp)
  );

  // subordinate model: 16 words, configurable wait states and error injection
  logic [31:0] mem [16];
  bit          in_dp = 0, err_mode = 0;
  int          wcnt = 0, wait_cfg = 0, xfer_cnt = 0;
  logic [31:0] sl_addr = '0;
  logic [2:0]  sl_size = '0;
  logic        sl_write = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      hready = 1'b1; hresp = 1'b0; in_dp = 0;
    end else begin
      if (in_dp) begin
        if (wcnt > 0) begin
          wcnt--; hready = 1'b0; hresp = err_mode && (wcnt == 0);
        end else begin
          hready = 1'b1; hresp = err_mode; in_dp = 0;
          if (!err_mode) begin
            if (sl_write) begin
              for (int l = 0; l < 4; l++) begin
                bit en;
                case (sl_size)
                  3'd0: en = (l == int'(sl_addr[1:0]));
                  3'd1: en = ((l / 2) == int'(sl_addr[1]));
                  default: en = 1;
                endcase
                if (en) mem[sl_addr[5:2]][l*8 +: 8] = hwdata[l*8 +: 8];
              end
            end else hrdata = mem[sl_addr[5:2]];
          end else hrdata = 32'hDEAD_BEEF;
        end
      end else begin
        hready = 1'b1; hresp = 1'b0;
      end
      if (!in_dp && hready && htrans == 2'b10) begin
        sl_addr = haddr; sl_size = hsize; sl_write = hwrite;
        in_dp = 1; xfer_cnt++;
        wcnt = (err_mode && wait_cfg < 1) ? 1 : wait_cfg;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] i, input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_idx = i; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] i, output logic [7:0] v);
    @(negedge clk); cfg_rd = 1'b1; cfg_idx = i;
    @(negedge clk); cfg_rd = 1'b0; v = cfg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stage(input logic [31:0] a, input logic [31:0] d, input logic [7:0] k);
    for (int b = 0; b < 4; b++) cfg_write(8'(8'hF0 + b), a[(3-b)*8 +: 8]);
    for (int b = 0; b < 4; b++) cfg_write(8'(8'hF4 + b), d[(3-b)*8 +: 8]);
    cfg_write(8'hF8, k);
  endtask

  task automatic fetch_word(output logic [31:0] w);
    logic [7:0] v;
    w = '0;
    for (int b = 0; b < 4; b++) begin
      cfg_read(8'(8'hF4 + b), v);
      w = {w[23:0], v};
    end
  endtask

  function automatic logic [2:0] exp_size(input int k);
    return (k == 0) ? 3'd0 : (k == 1) ? 3'd1 : 3'd2;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input int k);
    return (k == 0) ? a : (k == 1) ? (a & ~32'h1) : (a & ~32'h3);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [31:0] w, a, d, old, ex;
    int c0;
    for (int i = 0; i < 16; i++) mem[i] = 32'hA0B0_C0D0 ^ (i * 32'h0103_0507);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 htrans", 32'(htrans), 32'h0);
    check("R1 rdata", 32'(cfg_rdata), 32'h0);
    cfg_read(8'h30, v); check("R1 enable", 32'(v), 32'h0);

    // R2 disabled bridge ignores staging and triggers
    cfg_write(8'hF0, 8'h12);
    cfg_write(8'hFE, 8'hCF);
    idle(10);
    check("R2 no xfer while off", 32'(xfer_cnt), 32'd0);
    cfg_write(8'h30, 8'h01);
    cfg_read(8'h30, v); check("R2 enable readback", 32'(v), 32'h01);
    cfg_read(8'hF0, v); check("R2 ignored write", 32'(v), 32'h0);
    cfg_write(8'hF8, 8'h05);
    cfg_write(8'h30, 8'h03);
    cfg_read(8'hF8, v); check("R2 read while off", 32'(v), 32'h0);
    cfg_write(8'hFE, 8'hCF);
    cfg_read(8'hFE, v);
    idle(10);
    check("R2 no trigger with 0x03", 32'(xfer_cnt), 32'd0);
    cfg_write(8'h30, 8'h01);
    cfg_read(8'hF8, v); check("R2 value retained", 32'(v), 32'h05);

    // R3 staging readback, MSB first
    stage(32'h1122_3344, 32'h5566_7788, 8'h9C);
    for (int b = 0; b < 4; b++) begin
      cfg_read(8'(8'hF0 + b), v); check("R3 addr byte", 32'(v), 32'((32'h1122_3344 >> ((3-b)*8)) & 32'hFF));
      cfg_read(8'(8'hF4 + b), v); check("R3 data byte", 32'(v), 32'((32'h5566_7788 >> ((3-b)*8)) & 32'hFF));
    end
    cfg_read(8'hF8, v); check("R3 type", 32'(v), 32'h9C);

    // R4 non-key write to trigger starts nothing
    c0 = xfer_cnt;
    cfg_write(8'hFE, 8'h5A);
    idle(10);
    check("R4 non-key no start", 32'(xfer_cnt), 32'(c0));

    // write sweep: every type x every address low pair
    for (int k = 0; k < 4; k++) begin
      for (int lo = 0; lo < 4; lo++) begin
        int n = k * 4 + lo;
        a = {8'h9A, 8'h5C, 8'h7E, 2'b00, 4'(n), 2'(lo)};
        d = 32'h1F2E_3D4C + n * 32'h0101_0101;
        wait_cfg = n % 3;
        stage(a, d, 8'(k));
        old = mem[n]; c0 = xfer_cnt;
        cfg_write(8'hFE, 8'hCF);
        idle(14);
        check("R4 one write xfer", 32'(xfer_cnt), 32'(c0 + 1));
        check("R4 hwrite", 32'(sl_write), 32'h1);
        check("R6 haddr", sl_addr, exp_addr(a, k));
        check("R6 hsize", 32'(sl_size), 32'(exp_size(k)));
        case (exp_size(k))
          3'd0: ex = (old & ~(32'hFF << (a[1:0]*8))) | ({24'h0, d[7:0]} << (a[1:0]*8));
          3'd1: ex = (old & ~(32'hFFFF << (a[1]*16))) | ({16'h0, d[15:0]} << (a[1]*16));
          default: ex = d;
        endcase
        check("R7 written lanes", mem[n], ex);
        check("R9 htrans idle", 32'(htrans), 32'h0);
      end
    end

    // read sweep
    for (int k = 0; k < 4; k++) begin
      for (int lo = 0; lo < 4; lo++) begin
        int n = 15 - (k * 4 + lo);
        a = {8'h3B, 8'h00, 8'hC1, 2'b00, 4'(n), 2'(lo)};
        wait_cfg = (k + lo) % 4;
        stage(a, 32'hFFFF_FFFF, 8'(k == 3 ? 8'h77 : k));
        c0 = xfer_cnt;
        cfg_read(8'hFE, v);
        check("R10 idle status", 32'(v), 32'h0);
        idle(14);
        check("R5 one read xfer", 32'(xfer_cnt), 32'(c0 + 1));
        check("R5 hwrite low", 32'(sl_write), 32'h0);
        check("R6 read hsize", 32'(sl_size), 32'(exp_size(k)));
        fetch_word(w);
        case (exp_size(k))
          3'd0: ex = (mem[n] >> (a[1:0]*8)) & 32'hFF;
          3'd1: ex = (mem[n] >> (a[1]*16)) & 32'hFFFF;
          default: ex = mem[n];
        endcase
        check("R8 read lanes", w, ex);
      end
    end

    // R10 busy flag and triggers ignored while busy
    wait_cfg = 4;
    stage(32'h0000_0020, 32'hCAFE_F00D, 8'h02);
    c0 = xfer_cnt;
    cfg_write(8'hFE, 8'hCF);
    cfg_read(8'hFE, v);
    check("R10 busy bit", 32'(v), 32'h01);
    cfg_write(8'hFE, 8'hCF);
    idle(16);
    check("R10 busy triggers ignored", 32'(xfer_cnt), 32'(c0 + 1));
    check("R10 word written", mem[8], 32'hCAFE_F00D);

    // R11 sticky error
    wait_cfg = 0; err_mode = 1;
    old = mem[9];
    stage(32'h0000_0024, 32'h0BAD_0BAD, 8'h02);
    cfg_write(8'hFE, 8'hCF);
    idle(14);
    err_mode = 0;
    check("R11 failed write leaves target", mem[9], old);
    cfg_read(8'hFE, v);
    check("R11 error set", 32'(v), 32'h02);
    idle(14);
    cfg_read(8'hFE, v);
    check("R11 error sticky", 32'(v), 32'h02);
    idle(14);
    err_mode = 1;
    cfg_write(8'hF7, 8'h5E);
    cfg_read(8'hFE, v);
    idle(14);
    err_mode = 0;
    cfg_read(8'hF7, v);
    check("R11 failed read keeps data", 32'(v), 32'h5E);
    cfg_write(8'hFE, 8'h00);
    cfg_read(8'hFE, v);
    check("R11 error cleared", 32'(v), 32'h00);
    idle(14);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule